// File: doc/BRIEF.md
# GPIO Pad Control Register Bank

This block keeps the control and I/O settings for a bank of general-purpose pins and turns them into the signals that steer each pad. A plain register bus reaches every setting: an address, a write strobe with write data, and a read-data port that returns the addressed word in the same cycle. Each pin owns two words. Pin `p` has its control word at address `2p` and its I/O word at address `2p+1`.

The control word packs four fields. The alternate-function index sits in bits `[MUX_W-1:0]`, where `MUX_W` is the ceiling of log2(`NFUNCS`). The 2-bit bias selector sits in bits `[5:4]`. The 3-bit drive code sits in bits `[8:6]`. The direction bit sits in bit 9. The I/O word holds the output level in bit 0, which can be read and written. Bit 1 holds the synchronized pad input and is read-only.

The block drives the following pad signals for every pin: output level, output enable, pull-up request, pull-down request, keeper enable, drive code and function index. A bias code of 2 selects keeper mode. While the pin is an input, keeper mode holds the line at its last level by pulling toward it.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset every pin has output enable 0, no pull, keeper off, drive code 0, function 0 and output level 0. Every control word reads 0.
- R2: Bias code `[5:4]` has four values. 0 requests no pull. 1 requests pull-down. 2 enables the keeper. 3 requests pull-up. Pull-up and pull-down are never requested together on one pin.
- R3: The drive code in bits `[8:6]` appears on that pin's `pad_drv` slice and reads back unchanged. It stands for a strength of (code+1)×2 mA, so codes 0 through 7 cover 2 mA through 16 mA.
- R4: Control bit 9 drives `pad_oe`, where 1 means driven and 0 means input. A pin's output enable changes only on a write to that pin's control word.
- R5: The function field `[MUX_W-1:0]` drives `pad_func`. A write whose function value is `NFUNCS` or above leaves the stored function unchanged. The other fields of that same write still take effect.
- R6: I/O bit 0 holds the output level and drives `pad_out` whatever the direction. Software can therefore preset the level before it sets output enable, and the pad never shows a stale level.
- R7: I/O bit 1 returns the pad input after a two-flop synchronizer. A change on `pad_in` becomes readable after two clock edges, whatever the direction setting.
- R8: In keeper mode with output enable 0, the pull request follows the synchronized input: pull-up when it is 1, pull-down when it is 0. In keeper mode with output enable 1, neither pull is requested.
- R9: Writes to the read-only input bit and to unused bits have no effect. Unused bits read as 0.
- R10: Addresses at or above `2*NPINS` read as 0. Writes to them change no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| pad_in | input | NPINS | Raw pad input levels |
| pad_out | output | NPINS | Output level per pin |
| pad_oe | output | NPINS | Output enable per pin |
| pad_pu | output | NPINS | Pull-up request per pin |
| pad_pd | output | NPINS | Pull-down request per pin |
| pad_keep | output | NPINS | Keeper enable per pin |
| pad_drv | output | 3*NPINS | Drive code per pin, 3 bits each |
| pad_func | output | MUX_W*NPINS | Function index per pin |

## Verification
The assertions check several properties on every cycle. Pull-up and pull-down never appear together. The function index never leaves its legal range. Direction, drive and output level hold steady unless their own word is written. Unmapped reads return zero, and the pad state is clean in the first cycle after reset. Other behaviours need the directed scenarios to show them: the two-edge input latency, the keeper tracking the input and stepping aside when the pin drives, the rejection of an out-of-range function code while the other fields update, and the masking of read-only and unused bits.

// File: rtl/gpio_pad_bank.sv
`timescale 1ns/1ps
module gpio_pad_bank #(
  parameter int NPINS  = 6,
  parameter int NFUNCS = 5,
  parameter int MUX_W  = (NFUNCS > 1) ? $clog2(NFUNCS) : 1,
  parameter int ADDR_W = $clog2(2 * NPINS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr_en,
  input  logic [15:0]              wdata,
  output logic [15:0]              rdata,
  input  logic [NPINS-1:0]         pad_in,
  output logic [NPINS-1:0]         pad_out,
  output logic [NPINS-1:0]         pad_oe,
  output logic [NPINS-1:0]         pad_pu,
  output logic [NPINS-1:0]         pad_pd,
  output logic [NPINS-1:0]         pad_keep,
  output logic [3*NPINS-1:0]       pad_drv,
  output logic [MUX_W*NPINS-1:0]   pad_func
);

  localparam int PIN_W   = ADDR_W - 1;
  localparam int BIAS_LO = 4;
  localparam int DRV_LO  = 6;
  localparam int OE_BIT  = 9;
  localparam int OUT_BIT = 0;
  localparam int IN_BIT  = 1;

  localparam logic [1:0] BIAS_NONE = 2'd0;
  localparam logic [1:0] BIAS_DOWN = 2'd1;
  localparam logic [1:0] BIAS_KEEP = 2'd2;
  localparam logic [1:0] BIAS_UP   = 2'd3;

  logic [MUX_W-1:0] mux_q  [NPINS];
  logic [1:0]       bias_q [NPINS];
  logic [2:0]       drv_q  [NPINS];
  logic [NPINS-1:0] oe_q, out_q, in_meta, in_sync;

  logic [PIN_W-1:0] sel_pin;
  logic             sel_io, mapped, func_ok;

  assign sel_pin = addr[ADDR_W-1:1];
  assign sel_io  = addr[0];
  assign mapped  = {1'b0, addr} < (ADDR_W + 1)'(2 * NPINS);
  assign func_ok = {1'b0, wdata[MUX_W-1:0]} < (MUX_W + 1)'(NFUNCS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_meta <= '0;
      in_sync <= '0;
    end else begin
      in_meta <= pad_in;
      in_sync <= in_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= '0;
      out_q <= '0;
      for (int i = 0; i < NPINS; i++) begin
        mux_q[i]  <= '0;
        bias_q[i] <= BIAS_NONE;
        drv_q[i]  <= '0;
      end
    end else if (wr_en && mapped) begin
      for (int i = 0; i < NPINS; i++) begin
        if (sel_pin == PIN_W'(i)) begin
          if (sel_io) begin
            out_q[i] <= wdata[OUT_BIT];
          end else begin
            oe_q[i]   <= wdata[OE_BIT];
            drv_q[i]  <= wdata[DRV_LO +: 3];
            bias_q[i] <= wdata[BIAS_LO +: 2];
            if (func_ok) mux_q[i] <= wdata[MUX_W-1:0];
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (mapped && sel_pin == PIN_W'(i)) begin
        if (sel_io) begin
          rdata[OUT_BIT] = out_q[i];
          rdata[IN_BIT]  = in_sync[i];
        end else begin
          rdata[MUX_W-1:0]     = mux_q[i];
          rdata[BIAS_LO +: 2]  = bias_q[i];
          rdata[DRV_LO +: 3]   = drv_q[i];
          rdata[OE_BIT]        = oe_q[i];
        end
      end
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = oe_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic keeper, hold;
    assign keeper = (bias_q[g] == BIAS_KEEP);
    assign hold   = keeper && !oe_q[g];

    assign pad_keep[g]              = keeper;
    assign pad_pu[g]                = (bias_q[g] == BIAS_UP)   || (hold &&  in_sync[g]);
    assign pad_pd[g]                = (bias_q[g] == BIAS_DOWN) || (hold && !in_sync[g]);
    assign pad_drv[3*g +: 3]        = drv_q[g];
    assign pad_func[MUX_W*g +: MUX_W] = mux_q[g];

    AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(pad_pu[g] && pad_pd[g])); // R2
    AST_FUNC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, pad_func[MUX_W*g +: MUX_W]} < (MUX_W + 1)'(NFUNCS)); // R5
    AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(2 * g)) |=> $stable(pad_oe[g])); // R4
    AST_DRV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(2 * g)) |=> $stable(pad_drv[3*g +: 3])); // R3
    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == ADDR_W'(2 * g + 1)) |=> $stable(pad_out[g])); // R6
    AST_KEEP_OFF_WHEN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_keep[g] && pad_oe[g]) |-> !(pad_pu[g] || pad_pd[g])); // R8
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0 && pad_keep == '0)); // R1
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, addr} >= (ADDR_W + 1)'(2 * NPINS)) |-> rdata == '0); // R10

endmodule

// File: tb/gpio_pad_bank_bench.sv
`timescale 1ns/1ps
module gpio_pad_bank_bench;
  localparam int NPINS = 6;
  localparam int NFUNCS = 5;
  localparam int MUX_W = 3;
  localparam int ADDR_W = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr_en = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [NPINS-1:0] pad_in = '0;
  logic [NPINS-1:0] pad_out, pad_oe, pad_pu, pad_pd, pad_keep;
  logic [3*NPINS-1:0] pad_drv;
  logic [MUX_W*NPINS-1:0] pad_func;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_pad_bank #(.NPINS(NPINS), .NFUNCS(NFUNCS)) u_gpio_pad_bank (
    .clk, .rst_n, .addr, .wr_en, .wdata, .rdata, .pad_in,
    .pad_out, .pad_oe, .pad_pu, .pad_pd, .pad_keep, .pad_drv, .pad_func);

  function automatic logic [15:0] cw(int mux, int bias, int drv, int oe);
    return 16'(mux) | 16'(bias << 4) | 16'(drv << 6) | 16'(oe << 9);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int a, output logic [15:0] d);
    addr = ADDR_W'(a);
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int p = 0; p < NPINS; p++) begin
      rd(2 * p, d);      check("R1 ctrl word", d, 0);
      rd(2 * p + 1, d);  check("R1 io word", d, 0);
    end
    check("R1 oe", pad_oe, 0);
    check("R1 pulls", {pad_pu, pad_pd, pad_keep}, 0);
    check("R1 drive", pad_drv, 0);
    check("R1 func", pad_func, 0);
    check("R1 out", pad_out, 0);
  endtask

  task automatic t_bias();
    wr(4, cw(0, 0, 0, 1)); check("R2 none", {pad_pu[2], pad_pd[2], pad_keep[2]}, 3'b000);
    wr(4, cw(0, 1, 0, 1)); check("R2 down", {pad_pu[2], pad_pd[2], pad_keep[2]}, 3'b010);
    wr(4, cw(0, 2, 0, 1)); check("R2 keeper", {pad_pu[2], pad_pd[2], pad_keep[2]}, 3'b001);
    wr(4, cw(0, 3, 0, 1)); check("R2 up", {pad_pu[2], pad_pd[2], pad_keep[2]}, 3'b100);
  endtask

  task automatic t_drive();
    logic [15:0] d;
    for (int c = 0; c < 8; c++) begin
      wr(8, cw(0, 0, c, 0));
      check("R3 pad_drv", pad_drv[12 +: 3], c);
      rd(8, d);
      check("R3 strength mA", (((d >> 6) & 7) + 1) * 2, 2 + 2 * c);
    end
  endtask

  task automatic t_direction();
    wr(3, 16'h0001);
    check("R6 preset level", pad_out[1], 1);
    check("R6 still input", pad_oe[1], 0);
    wr(2, cw(0, 0, 0, 1));
    check("R4 driven", pad_oe[1], 1);
    check("R6 level kept", pad_out[1], 1);
    wr(0, cw(1, 0, 0, 0));
    check("R4 other pin write", pad_oe[1], 1);
    wr(2, cw(0, 0, 0, 0));
    check("R4 back to input", pad_oe[1], 0);
  endtask

  task automatic t_input();
    logic [15:0] d;
    @(negedge clk); pad_in[3] = 1;
    @(negedge clk); rd(7, d); check("R7 one edge", d[1], 0);
    @(negedge clk); rd(7, d); check("R7 two edges", d[1], 1);
    wr(6, cw(0, 0, 0, 1));
    @(negedge clk); pad_in[3] = 0;
    @(negedge clk); @(negedge clk); rd(7, d); check("R7 while driven", d[1], 0);
    @(negedge clk); pad_in[3] = 1;
    @(negedge clk); @(negedge clk); rd(7, d); check("R7 while driven high", d[1], 1);
  endtask

  task automatic t_keeper();
    wr(10, cw(0, 2, 0, 0));
    @(negedge clk); pad_in[5] = 1;
    @(negedge clk); @(negedge clk);
    check("R8 keeper high", {pad_pu[5], pad_pd[5]}, 2'b10);
    pad_in[5] = 0;
    @(negedge clk); @(negedge clk);
    check("R8 keeper low", {pad_pu[5], pad_pd[5]}, 2'b01);
    wr(10, cw(0, 2, 0, 1));
    check("R8 keeper driven", {pad_pu[5], pad_pd[5], pad_keep[5]}, 3'b001);
  endtask

  task automatic t_readonly();
    logic [15:0] d;
    wr(7, 16'hFFFE);
    rd(7, d); check("R9 io word", d, 16'h0002);
    check("R9 pad_out", pad_out[3], 0);
    wr(6, 16'hFC08 | cw(1, 1, 3, 0));
    rd(6, d); check("R9 ctrl unused bits", d, cw(1, 1, 3, 0));
  endtask

  task automatic t_mux();
    logic [15:0] d;
    wr(0, cw(4, 0, 0, 0)); check("R5 func 4", pad_func[0 +: 3], 4);
    wr(0, cw(6, 0, 5, 0));
    check("R5 func rejected", pad_func[0 +: 3], 4);
    check("R5 other fields taken", pad_drv[0 +: 3], 5);
    wr(0, cw(5, 3, 1, 0));
    rd(0, d); check("R5 readback", d, cw(4, 3, 1, 0));
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    logic [NPINS-1:0] oe0, out0;
    logic [3*NPINS-1:0] drv0;
    logic [MUX_W*NPINS-1:0] fn0;
    oe0 = pad_oe; out0 = pad_out; drv0 = pad_drv; fn0 = pad_func;
    for (int a = 2 * NPINS; a < 16; a++) begin
      rd(a, d); check("R10 read zero", d, 0);
    end
    wr(12, 16'hFFFF);
    wr(13, 16'hFFFF);
    check("R10 write ignored", {pad_oe, pad_out, pad_drv, pad_func}, {oe0, out0, drv0, fn0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bias();
    t_drive();
    t_direction();
    t_input();
    t_keeper();
    t_readonly();
    t_mux();
    t_unmapped();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule